// File: doc/BRIEF.md
# Iterative CORDIC Sine and Cosine Engine

This block returns the cosine and sine of an angle. The angle is a signed fixed-point value in radians. The engine is folded in time. A single set of three add/subtract units serves the x, y and residual-angle paths. Two sign-extending shifters take their shift amount from the iteration counter. A small table holds the arctangent step constants. A three-state controller steps through the work one micro-rotation per clock, and it runs as many micro-rotations as the data width.

The x register starts at the reciprocal of the CORDIC gain and y starts at zero, so the outputs come out at unit scale with no correcting multiply. An angle beyond a quarter turn is first moved by half a turn into the convergent range. The engine then negates both results to compensate. A caller presents an angle with a one-cycle start and later sees a one-cycle done, with the results held steady until the next done.

Top module: `cordic_sincos`

## Requirements
- R1: For an angle in [-pi/2, +pi/2], given as signed Q3.(W-3) radians on `angle_in`, `cos_out` and `sin_out` are signed Q2.(W-2) values (1.0 = 2^(W-2)) within 4 LSB of the true cosine and sine of that quantised angle.
- R2: For an angle in (pi/2, pi] or [-pi, -pi/2), the engine subtracts pi (positive angles) or adds pi (negative angles) and negates both results, so the outputs stay within 4 LSB of the true cosine and sine.
- R3: The engine performs exactly W micro-rotations, one per clock, and `done` rises exactly W+1 clock edges after the edge that accepts `start`.
- R4: `done` is high for exactly one clock cycle per accepted start.
- R5: A `start` that arrives between the accepting edge and the `done` cycle is ignored: it produces no extra result and does not disturb the running computation.
- R6: `cos_out` and `sin_out` change only in the cycle in which `done` is high, and hold their values between pulses.
- R7: While reset is asserted, `done`, `cos_out` and `sin_out` are all zero.
- R8: A `start` presented in the cycle in which `done` is high is accepted, so back-to-back computations leave no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation; sampled only while idle |
| angle_in | input | W | Signed angle in radians, Q3.(W-3) |
| done | output | 1 | One-cycle pulse when results are valid |
| cos_out | output | W | Cosine, signed Q2.(W-2) |
| sin_out | output | W | Sine, signed Q2.(W-2) |

## Verification
A sweep in steps of pi/16 from -pi to +pi covers both the direct range and the folded range. Because it hits the exact quarter and half turns, it can tell a wrong fold boundary or a missing negation apart from a bad rotation direction. Off-grid angles just outside +-pi/2 and a one-LSB angle test convergence where the residual angle is smallest. A start pulse held while the engine is busy must not yield a second result or change the first one. Back-to-back requests issued in the done cycle, each timed against its accepting edge, separate a correct iteration count from an off-by-one in the controller.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   // pi/4 and 1/K as unsigned fixed-point constants
   localparam longint unsigned PI4_Q60  = 64'd905502432259640374;
   localparam longint unsigned KINV_Q30 = 64'd652032875;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ROTATE = 2'd1,
      ST_EMIT   = 2'd2
   } cordic_state_e;

   // arctan(2^-i) scaled by 2^60, series expansion for i >= 1
   function automatic longint unsigned atan_q60(input int i);
      longint unsigned acc;
      longint unsigned term;
      int e;
      acc = 64'd0;
      if (i == 0) return PI4_Q60;
      for (int k = 0; k < 32; k++) begin
         e = 60 - (2 * k + 1) * i;
         if (e >= 0) begin
            term = (64'd1 << e) / 64'(2 * k + 1);
            if (k % 2 == 0) acc = acc + term;
            else            acc = acc - term;
         end
      end
      return acc;
   endfunction

   // rescale a 2^60 constant to 'frac' fractional bits with rounding
   function automatic longint unsigned q60_to(input longint unsigned v, input int frac);
      return (v + (64'd1 << (59 - frac))) >> (60 - frac);
   endfunction

   // reciprocal CORDIC gain at 'frac' fractional bits
   function automatic longint unsigned kinv_fix(input int frac);
      if (frac >= 30) return KINV_Q30 << (frac - 30);
      return (KINV_Q30 + (64'd1 << (29 - frac))) >> (30 - frac);
   endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
   parameter int ITER = 16,
   parameter int DW   = 18,
   parameter int FA   = 15,
   localparam int IDXW = (ITER > 1) ? $clog2(ITER) : 1
) (
   input  logic [IDXW-1:0]       idx_i,
   output logic signed [DW-1:0]  atan_o
);

   logic signed [DW-1:0] step_tbl [ITER];

   for (genvar g = 0; g < ITER; g++) begin : g_step
      assign step_tbl[g] = DW'(cordic_pkg::q60_to(cordic_pkg::atan_q60(g), FA));
   end

   assign atan_o = step_tbl[idx_i];

endmodule

// File: rtl/cordic_fold.sv
module cordic_fold #(
   parameter int W       = 16,
   parameter int DW      = 18,
   parameter int FA      = 15,
   parameter bit FOLD_EN = 1'b1
) (
   input  logic signed [W-1:0]   angle_i,
   output logic signed [DW-1:0]  z_o,
   output logic                  flip_o
);

   localparam logic signed [DW-1:0] HALF_PI_C =
      DW'(cordic_pkg::q60_to(cordic_pkg::PI4_Q60 * 64'd2, FA));
   localparam logic signed [DW-1:0] FULL_PI_C =
      DW'(cordic_pkg::q60_to(cordic_pkg::PI4_Q60 * 64'd4, FA));

   logic signed [DW-1:0] z_wide;

   always_comb begin
      z_wide = DW'(angle_i);
      z_wide = z_wide <<< (DW - W);
   end

   if (FOLD_EN) begin : g_fold
      always_comb begin
         if (z_wide > HALF_PI_C) begin
            z_o    = z_wide - FULL_PI_C;
            flip_o = 1'b1;
         end else if (z_wide < -HALF_PI_C) begin
            z_o    = z_wide + FULL_PI_C;
            flip_o = 1'b1;
         end else begin
            z_o    = z_wide;
            flip_o = 1'b0;
         end
      end
   end else begin : g_nofold
      assign z_o    = z_wide;
      assign flip_o = 1'b0;
   end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
   parameter int ITER = 16,
   localparam int IDXW = (ITER > 1) ? $clog2(ITER) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             load_o,
   output logic             step_o,
   output logic             emit_o,
   output logic             busy_o,
   output logic [IDXW-1:0]  idx_o
);

   import cordic_pkg::*;

   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ITER - 1);

   cordic_state_e   state_q, state_d;
   logic [IDXW-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      load_o  = 1'b0;
      step_o  = 1'b0;
      emit_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               cnt_d   = '0;
               state_d = ST_ROTATE;
            end
         end
         ST_ROTATE: begin
            step_o = 1'b1;
            if (cnt_q == LAST_IDX) state_d = ST_EMIT;
            else                   cnt_d   = cnt_q + 1'b1;
         end
         ST_EMIT: begin
            emit_o  = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign idx_o  = cnt_q;

endmodule

// File: rtl/cordic_rot_dp.sv
module cordic_rot_dp #(
   parameter int ITER = 16,
   parameter int DW   = 18,
   parameter logic signed [DW-1:0] X_INIT = '0,
   localparam int IDXW = (ITER > 1) ? $clog2(ITER) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic                  step_i,
   input  logic signed [DW-1:0]  z_init_i,
   input  logic [IDXW-1:0]       idx_i,
   input  logic signed [DW-1:0]  atan_i,
   output logic signed [DW-1:0]  x_o,
   output logic signed [DW-1:0]  y_o
);

   logic signed [DW-1:0] x_q, y_q, z_q;
   logic signed [DW-1:0] x_sh, y_sh;
   logic signed [DW-1:0] x_nx, y_nx, z_nx;
   logic                 ccw;

   always_comb begin
      ccw  = ~z_q[DW-1];
      x_sh = x_q >>> idx_i;
      y_sh = y_q >>> idx_i;
      x_nx = ccw ? (x_q - y_sh)   : (x_q + y_sh);
      y_nx = ccw ? (y_q + x_sh)   : (y_q - x_sh);
      z_nx = ccw ? (z_q - atan_i) : (z_q + atan_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         z_q <= '0;
      end else if (load_i) begin
         x_q <= X_INIT;
         y_q <= '0;
         z_q <= z_init_i;
      end else if (step_i) begin
         x_q <= x_nx;
         y_q <= y_nx;
         z_q <= z_nx;
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
   parameter int W         = 16,
   parameter int GUARD     = 2,
   parameter bit FOLD_EN   = 1'b1,
   parameter bit ROUND_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [W-1:0]  angle_in,
   output logic          done,
   output logic [W-1:0]  cos_out,
   output logic [W-1:0]  sin_out
);

   localparam int ITER   = W;
   localparam int DW     = W + GUARD;
   localparam int FA     = W - 3 + GUARD;
   localparam int FO     = W - 2 + GUARD;
   localparam int IDXW   = (ITER > 1) ? $clog2(ITER) : 1;
   localparam int RND_SH = (GUARD > 0) ? GUARD - 1 : 0;
   localparam logic signed [DW-1:0] RND_C  = DW'(1) <<< RND_SH;
   localparam logic signed [DW-1:0] KINV_C = DW'(cordic_pkg::kinv_fix(FO));

   if (W < 8 || W > 32) begin : g_bad_width
      $error("cordic_sincos: W must lie in 8..32");
   end
   if (GUARD < 0 || GUARD > 8) begin : g_bad_guard
      $error("cordic_sincos: GUARD must lie in 0..8");
   end

   logic                  load, step, emit, busy;
   logic [IDXW-1:0]       idx;
   logic signed [DW-1:0]  z_init, atan_step, x_res, y_res;
   logic                  flip_in, flip_q;
   logic signed [W-1:0]   x_nar, y_nar;

   cordic_ctrl #(.ITER(ITER)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .load_o  (load),
      .step_o  (step),
      .emit_o  (emit),
      .busy_o  (busy),
      .idx_o   (idx)
   );

   cordic_fold #(.W(W), .DW(DW), .FA(FA), .FOLD_EN(FOLD_EN)) u_fold (
      .angle_i (angle_in),
      .z_o     (z_init),
      .flip_o  (flip_in)
   );

   cordic_atan_rom #(.ITER(ITER), .DW(DW), .FA(FA)) u_rom (
      .idx_i  (idx),
      .atan_o (atan_step)
   );

   cordic_rot_dp #(.ITER(ITER), .DW(DW), .X_INIT(KINV_C)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load),
      .step_i   (step),
      .z_init_i (z_init),
      .idx_i    (idx),
      .atan_i   (atan_step),
      .x_o      (x_res),
      .y_o      (y_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flip_q <= 1'b0;
      else if (load) flip_q <= flip_in;
   end

   if (GUARD == 0) begin : g_exact
      assign x_nar = W'(x_res);
      assign y_nar = W'(y_res);
   end else if (ROUND_OUT) begin : g_round
      assign x_nar = W'((x_res + RND_C) >>> GUARD);
      assign y_nar = W'((y_res + RND_C) >>> GUARD);
   end else begin : g_trunc
      assign x_nar = W'(x_res >>> GUARD);
      assign y_nar = W'(y_res >>> GUARD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         cos_out <= '0;
         sin_out <= '0;
      end else begin
         done <= emit;
         if (emit) begin
            cos_out <= flip_q ? -x_nar : x_nar;
            sin_out <= flip_q ? -y_nar : y_nar;
         end
      end
   end

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
   parameter int W = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [W-1:0]  cos_out,
   input logic [W-1:0]  sin_out
);

   localparam int LAT_END = W + 2;
   localparam int ONE     = 1 << (W - 2);

   logic [7:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_q <= '0;
      else if (start && !busy)   lat_q <= 8'd1;
      else if (done)             lat_q <= '0;
      else if (lat_q != 8'd0)    lat_q <= lat_q + 8'd1;
   end

   // R3: done exactly W+1 edges after the accepting edge
   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done == (lat_q == 8'(LAT_END)));

   // R4: single-cycle done pulse
   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: a start while busy keeps the engine busy and is not restarted
   a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done && lat_q < 8'(LAT_END - 1)) |=> busy);

   // R6: results hold outside done
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(cos_out) && $stable(sin_out)));

   // R1: results stay inside unit range
   a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($signed(cos_out) <= ONE + 4 && $signed(cos_out) >= -ONE - 4 &&
                $signed(sin_out) <= ONE + 4 && $signed(sin_out) >= -ONE - 4));

endmodule

bind cordic_sincos cordic_sincos_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .cos_out (cos_out),
   .sin_out (sin_out)
);

// File: tb/cordic_sincos_bench.sv
module cordic_sincos_bench;

   localparam int    W     = 16;
   localparam real   PI    = 3.14159265358979323846;
   localparam real   A_SC  = 8192.0;
   localparam real   O_SC  = 16384.0;
   localparam int    TOL   = 4;

   typedef struct {
      int     c;
      int     s;
      longint acc;
      bit     folded;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  angle_in = '0;
   logic          done;
   logic [W-1:0]  cos_out, sin_out;

   int     checks = 0;
   int     errors = 0;
   longint cyc = 0;
   bit     finished = 1'b0;
   bit     have_last = 1'b0;
   bit     prev_done = 1'b0;
   int     last_c = 0, last_s = 0;
   exp_t   exp_q[$];

   always #5 clk = ~clk;

   cordic_sincos u_cordic_sincos (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .angle_in (angle_in),
      .done     (done),
      .cos_out  (cos_out),
      .sin_out  (sin_out)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int absi(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // Driver: present one angle, push its expected result
   task automatic drive(input real a);
      int   q;
      real  ar;
      exp_t e;
      q  = $rtoi(a * A_SC + ((a >= 0.0) ? 0.5 : -0.5));
      ar = real'(q) / A_SC;
      e.c = $rtoi($cos(ar) * O_SC + (($cos(ar) >= 0.0) ? 0.5 : -0.5));
      e.s = $rtoi($sin(ar) * O_SC + (($sin(ar) >= 0.0) ? 0.5 : -0.5));
      e.acc = cyc + 1;
      e.folded = (ar > PI / 2.0) || (ar < -PI / 2.0);
      angle_in = W'(q);
      start    = 1'b1;
      exp_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
   endtask

   // Monitor: pop and compare on done, check hold and pulse width
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            check(!prev_done, "R4 done width", int'(prev_done), 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected result", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               // R3: done W+1 edges after acceptance
               check(cyc == e.acc + W + 1, "R3 latency", int'(cyc - e.acc), W + 1);
               check(absi(int'($signed(cos_out)) - e.c) <= TOL,
                     e.folded ? "R2 cos folded" : "R1 cos", int'($signed(cos_out)), e.c);
               check(absi(int'($signed(sin_out)) - e.s) <= TOL,
                     e.folded ? "R2 sin folded" : "R1 sin", int'($signed(sin_out)), e.s);
            end
            last_c    = int'($signed(cos_out));
            last_s    = int'($signed(sin_out));
            have_last = 1'b1;
         end else if (have_last) begin
            check(int'($signed(cos_out)) == last_c && int'($signed(sin_out)) == last_s,
                  "R6 hold", int'($signed(cos_out)), last_c);
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R3 watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R7: reset state
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R7 reset done", int'(done), 0);
      check(cos_out == '0, "R7 reset cos", int'(cos_out), 0);
      check(sin_out == '0, "R7 reset sin", int'(sin_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R7 done after release", int'(done), 0);

      // R1/R2/R8: sweep -pi..pi in pi/16 steps, back-to-back in the done cycle
      for (int k = -16; k <= 16; k++) begin
         drive(real'(k) * PI / 16.0);
         wait_done();
      end

      // R2 boundary just outside the quarter turn, R1 off-grid and tiny angles
      drive(PI / 2.0 + 0.002);  wait_done();
      drive(-PI / 2.0 - 0.002); wait_done();
      drive(0.3);               wait_done();
      drive(-1.2);              wait_done();
      drive(1.0 / A_SC);        wait_done();
      drive(PI / 2.0 - 0.002);  wait_done();

      // R5: a second start while busy must be ignored
      drive(0.7);
      repeat (3) @(negedge clk);
      angle_in = W'(-8000);
      start    = 1'b1;
      repeat (3) @(negedge clk);
      start    = 1'b0;
      wait_done();
      repeat (W + 6) @(negedge clk);
      check(exp_q.size() == 0, "R5 pending results", exp_q.size(), 0);
      check(done == 1'b0, "R5 no second done", int'(done), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule